// File: doc/BRIEF.md
# Configurable GPIO Port Controller with Brown-out Override

This block controls one port of general-purpose pins, eight by default. Software programs it over a simple synchronous register bus. Registers set each pin's output data, direction, pull-up request, open-drain mode and brown-out behaviour. For each pin the block produces an output enable, an output value and a pull-up enable for the pad. It also synchronizes the pad inputs, so software can read them back.

A brown-out input comes from an external supply monitor. While it is high, every pin whose brown-out control bit is set becomes an input with its pull-up on. This happens in hardware, whatever the pin's direction bit says. Pins whose control bit is clear keep their programmed setup.

A parameter selects one of two variants:
- **Plain variant:** has the open-drain register and no interrupt logic.
- **Interrupt variant:** has no open-drain register. It adds per-pin change detection with sticky flags and one interrupt output.

The register bus is control traffic, not a data stream. It has no valid/ready handshake and no back-pressure. A write with `bus_en` and `bus_we` high completes on the next rising clock edge. Read data is combinational while `bus_en` is high and `bus_we` is low, and is 0 otherwise.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset:
  - Direction, data, open-drain, interrupt-enable and flag registers read 0.
  - Every brown-out control bit reads 1.
  - The pull-up register reads the parameter `PULL_RST` (default 0xF0).
- R2: Register map: data at 0, direction at 1, pull-up at 2, open-drain at 3, brown-out control at 4, interrupt enable at 5, change flags at 6.
  - A direction bit of 1 makes the pin an output and drives `pad_oe` high (push-pull).
  - A direction bit of 0 keeps `pad_oe` low.
- R3: Reading offset 0 returns:
  - the data register bit for pins that currently act as outputs;
  - the synchronized pad level for input pins. A pad change becomes visible in the read after exactly two rising edges.
- R4: `pad_pu` follows the pull-up bit for input pins. It is 0 for pins that act as outputs.
- R5: An output pin with its open-drain bit at 1 has `pad_out` at 0. Its `pad_oe` is high only while its data bit is 0.
- R6: While `brownout` is high, each pin with brown-out control bit 1 has `pad_oe` low and `pad_pu` high, whatever its direction bit.
- R7: A pin with brown-out control bit 0 has the same `pad_oe`, `pad_out` and `pad_pu` whether `brownout` is high or low.
- R8: In the interrupt variant (`CHANGE_IRQ`=1), writes to offset 3 are ignored and it reads 0. Every output is push-pull.
- R9: In the interrupt variant:
  - A change of a synchronized pin level sets that pin's flag on the third rising edge after the pad change, but only if its enable bit is 1.
  - Flags stay set until cleared.
- R10:
  - Writing 1 to a flag bit at offset 6 clears it; writing 0 leaves it.
  - `irq_o` is the OR of the flags whose enable bit is 1, so clearing an enable bit drops `irq_o` while the flag remains.
- R11:
  - Offset 7 reads 0.
  - In the plain variant, offsets 5 and 6 read 0 and `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access enable |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data (combinational) |
| brownout | input | 1 | Supply-low indication |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |
| pad_pu | output | WIDTH | Per-pin pull-up enable |
| irq_o | output | 1 | Pin-change interrupt |

## Verification
The hardest part to reach from the ports is the exact timing of the change flags. A pad edge passes through three flops before a flag can set, and the flag must stay clear one edge earlier. The bench changes `pad_in` at a falling edge, then reads the flag register after the second and after the third rising edge. The brown-out override depends on the brown-out bit, the direction bit and the control bit all at once. The bench therefore rotates a five-bit configuration across the pins, so every pin meets every combination both with and without brown-out. It runs this sweep on both variants side by side.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PULL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_ODRN  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_BOCTL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_IFLG  = 3'd6;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] PULL_RST = '0,
  parameter bit CHANGE_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  eff_dir,
  input  logic [WIDTH-1:0]  pin_level,
  input  logic [WIDTH-1:0]  flags,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  odrn_q,
  output logic [WIDTH-1:0]  boctl_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  flag_clr
);
  logic wr_any;
  assign wr_any = bus_en & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      pull_q  <= PULL_RST;
      boctl_q <= '1;
    end else if (wr_any) begin
      case (bus_addr)
        OFS_DATA:  data_q  <= bus_wdata;
        OFS_DIR:   dir_q   <= bus_wdata;
        OFS_PULL:  pull_q  <= bus_wdata;
        OFS_BOCTL: boctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  generate
    if (CHANGE_IRQ) begin : g_irq_regs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ien_q <= '0;
        else if (wr_any && bus_addr == OFS_IEN) ien_q <= bus_wdata;
      end
      assign odrn_q   = '0;
      assign flag_clr = (wr_any && bus_addr == OFS_IFLG) ? bus_wdata : '0;
    end else begin : g_od_regs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) odrn_q <= '0;
        else if (wr_any && bus_addr == OFS_ODRN) odrn_q <= bus_wdata;
      end
      assign ien_q    = '0;
      assign flag_clr = '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        OFS_DATA:  bus_rdata = (data_q & eff_dir) | (pin_level & ~eff_dir);
        OFS_DIR:   bus_rdata = dir_q;
        OFS_PULL:  bus_rdata = pull_q;
        OFS_ODRN:  bus_rdata = odrn_q;
        OFS_BOCTL: bus_rdata = boctl_q;
        OFS_IEN:   bus_rdata = ien_q;
        OFS_IFLG:  bus_rdata = flags;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_undef_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 3'd7) |-> (bus_rdata == '0));
  assert_bo_reset_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (boctl_q == '1));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brownout,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] odrn_q,
  input  logic [WIDTH-1:0] boctl_q,
  output logic [WIDTH-1:0] eff_dir,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic held;
      assign held       = brownout & boctl_q[i];
      assign eff_dir[i] = dir_q[i] & ~held;
      assign pad_oe[i]  = eff_dir[i] & ~(odrn_q[i] & data_q[i]);
      assign pad_out[i] = eff_dir[i] & ~odrn_q[i] & data_q[i];
      assign pad_pu[i]  = held | (~dir_q[i] & pull_q[i]);

      assert_oe_needs_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[i] |-> dir_q[i]);
      assert_pu_not_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_oe[i] && pad_pu[i]));
      assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[i] && odrn_q[i]) |-> !pad_out[i]);
      assert_bo_forces_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout && boctl_q[i]) |-> (!pad_oe[i] && pad_pu[i]));
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] level
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= pad_in;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_change_flags.sv
module gpio_change_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] ien_q,
  input  logic [WIDTH-1:0] flag_clr,
  output logic [WIDTH-1:0] flag_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_hit;

  assign edge_hit = level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level;
      flag_q <= (flag_q & ~flag_clr) | (edge_hit & ien_q);
    end
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !flag_clr[i]) |=> flag_q[i]);
      assert_flag_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(ien_q[i]));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] PULL_RST = 8'hF0,
  parameter bit CHANGE_IRQ = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              brownout,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu,
  output logic              irq_o
);
  logic [WIDTH-1:0] data_q, dir_q, pull_q, odrn_q, boctl_q, ien_q;
  logic [WIDTH-1:0] flag_clr, flag_q, level, eff_dir;

  gpio_cfg_regs #(.WIDTH(WIDTH), .PULL_RST(PULL_RST), .CHANGE_IRQ(CHANGE_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eff_dir(eff_dir), .pin_level(level), .flags(flag_q),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .odrn_q(odrn_q),
    .boctl_q(boctl_q), .ien_q(ien_q), .flag_clr(flag_clr)
  );

  gpio_pin_drive #(.WIDTH(WIDTH)) u_drive (
    .clk(clk), .rst_n(rst_n), .brownout(brownout),
    .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .odrn_q(odrn_q),
    .boctl_q(boctl_q), .eff_dir(eff_dir),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .level(level)
  );

  generate
    if (CHANGE_IRQ) begin : g_change
      gpio_change_flags #(.WIDTH(WIDTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .level(level), .ien_q(ien_q),
        .flag_clr(flag_clr), .flag_q(flag_q)
      );
    end else begin : g_nochange
      assign flag_q = '0;
    end
  endgenerate

  assign irq_o = |(flag_q & ien_q);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam int W = 8;
  localparam logic [W-1:0] PRST = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic brownout = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rd0, rd1, oe0, oe1, out0, out1, pu0, pu1;
  logic irq0, irq1;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.WIDTH(W), .PULL_RST(PRST), .CHANGE_IRQ(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .brownout(brownout), .pad_in(pad_in),
    .pad_oe(oe0), .pad_out(out0), .pad_pu(pu0), .irq_o(irq0));
  gpio_port_ctrl #(.WIDTH(W), .PULL_RST(PRST), .CHANGE_IRQ(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .brownout(brownout), .pad_in(pad_in),
    .pad_oe(oe1), .pad_out(out1), .pad_pu(pu1), .irq_o(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] r0, output logic [W-1:0] r1);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #0.5;
    r0 = rd0; r1 = rd1;
    bus_en = 0;
    #0.1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values at each offset
    rd(3'd0, a0, a1); chk("R1 data", {a0, a1}, 16'h0000);
    rd(3'd1, a0, a1); chk("R1 dir", {a0, a1}, 16'h0000);
    rd(3'd2, a0, a1); chk("R1 pull", {a0, a1}, {PRST, PRST});
    rd(3'd3, a0, a1); chk("R1 odrn", a1, 0);
    rd(3'd4, a0, a1); chk("R1 boctl", {a0, a1}, 16'hFFFF);
    rd(3'd5, a0, a1); chk("R1 ien", {a0, a1}, 0);
    rd(3'd6, a0, a1); chk("R1 flags", {a0, a1}, 0);
    chk("R1 pad_oe", {oe0, oe1}, 0);
    chk("R1 R4 pad_pu", {pu0, pu1}, {PRST, PRST});
    chk("R11 irq idle", {irq0, irq1}, 0);
    rd(3'd7, a0, a1); chk("R11 offset 7", {a0, a1}, 0);

    // R8: open-drain offset in interrupt variant
    wr(3'd3, 8'hFF);
    rd(3'd3, a0, a1); chk("R8 odrn ignored", a0, 0); chk("R8 odrn stored", a1, 8'hFF);

    // R2 R4 R5 R6 R7 R8: each pin walks all 32 configurations, without then with brown-out
    for (int c = 0; c < 64; c++) begin
      logic [W-1:0] d, o, p, dt, b;
      for (int i = 0; i < W; i++) begin
        logic [4:0] v;
        v = 5'((c + i * 7) % 32);
        d[i] = v[0]; o[i] = v[1]; p[i] = v[2]; dt[i] = v[3]; b[i] = v[4];
      end
      wr(3'd1, d); wr(3'd0, dt); wr(3'd2, p); wr(3'd3, o); wr(3'd4, b);
      brownout = (c >= 32);
      #0.5;
      for (int k = 0; k < 2; k++) begin
        logic [W-1:0] eo, eout, epu, od;
        od = (k == 0) ? '0 : o;
        for (int i = 0; i < W; i++) begin
          logic h, ed;
          h = brownout & b[i];
          ed = d[i] & ~h;
          eo[i] = ed & ~(od[i] & dt[i]);
          eout[i] = ed & ~od[i] & dt[i];
          epu[i] = h | (~d[i] & p[i]);
        end
        chk("R2 R5 R6 R7 pad_oe", (k == 0) ? oe0 : oe1, eo);
        chk("R2 R5 R8 pad_out", (k == 0) ? out0 : out1, eout);
        chk("R4 R6 R7 pad_pu", (k == 0) ? pu0 : pu1, epu);
      end
    end
    brownout = 0;
    wr(3'd4, 8'hFF);
    wr(3'd3, 8'h00);

    // R3: readback mix and synchronizer latency
    wr(3'd1, 8'h5A); wr(3'd0, 8'hC3);
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] oldp, newp;
      oldp = pad_in;
      newp = 8'((k * 17) ^ 8'h96);
      pad_in = newp;
      @(negedge clk);
      rd(3'd0, a0, a1);
      chk("R3 one edge", {a0, a1}, {2{(8'hC3 & 8'h5A) | (oldp & ~8'h5A)}});
      @(negedge clk);
      rd(3'd0, a0, a1);
      chk("R3 two edges", {a0, a1}, {2{(8'hC3 & 8'h5A) | (newp & ~8'h5A)}});
    end

    // R9 R10: change flags on the interrupt variant
    wr(3'd1, 8'h00);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    wr(3'd5, 8'h0F); wr(3'd6, 8'hFF);
    rd(3'd5, a0, a1); chk("R11 ien plain variant", a1, 0); chk("R10 ien readback", a0, 8'h0F);
    rd(3'd6, a0, a1); chk("R10 flags cleared", a0, 0);
    pad_in = 8'h21;
    @(negedge clk); @(negedge clk);
    rd(3'd6, a0, a1); chk("R9 no flag after two edges", a0, 0);
    @(negedge clk);
    rd(3'd6, a0, a1); chk("R9 flag on third edge", a0, 8'h01);
    chk("R10 irq raised", irq0, 1);
    chk("R11 plain irq", irq1, 0);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rd(3'd6, a0, a1); chk("R9 sticky", a0, 8'h01);
    wr(3'd6, 8'h00);
    rd(3'd6, a0, a1); chk("R10 write zero keeps", a0, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd6, a0, a1); chk("R10 write one clears", a0, 0);
    chk("R10 irq dropped", irq0, 0);
    wr(3'd5, 8'hF0);
    pad_in = 8'h80;
    repeat (4) @(negedge clk);
    rd(3'd6, a0, a1); chk("R9 enabled pin 7", a0, 8'h80); chk("R11 plain flags", a1, 0);
    chk("R10 irq pin 7", irq0, 1);
    wr(3'd5, 8'h00);
    chk("R10 irq gated by enable", irq0, 0);
    rd(3'd6, a0, a1); chk("R10 flag kept when disabled", a0, 8'h80);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rd(3'd6, a0, a1); chk("R9 disabled no new flag", a0, 8'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule